// File: doc/BRIEF.md
# Profile-Selected DDS Phase Generator

This block is the phase-generation core of a direct digital synthesizer. It holds four profiles, and each profile carries a 32-bit frequency step and a 14-bit phase shift. A 2-bit select input picks the profile in use. A 32-bit phase accumulator adds the chosen step on every clock, so the output frequency is step × f_clk / 2^32. The top 14 bits of the accumulator, plus the active profile's phase shift, form the 14-bit output phase. A later phase-to-amplitude stage reads that phase.

Software writes never reach the working values directly. Each write lands in a pending copy of one profile field, and a commit strobe copies all pending fields into the working set at once. This lets a profile that is not in use be reloaded, and lets the profile in use be retuned at a chosen instant. A mode input replaces the profile's step with an external swept step.

Top module: `dds_phase_gen`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the accumulator, the registered select and every pending and working profile field to zero, so `phase_out` reads 0 after the edge.
- R2: In single-tone mode (`sweep` = 0), each clock edge adds the working step of the registered profile to the accumulator, modulo 2^32.
- R3: In sweep mode (`sweep` = 1), each clock edge adds `sweep_ftw` to the accumulator instead of the profile step.
- R4: A write (`wr_en` = 1) stores into a pending field only. `wr_kind` = 0 selects the 32-bit step of profile `wr_prof` and takes all of `wr_data`. `wr_kind` = 1 selects its phase shift and takes `wr_data[13:0]`. Without a commit, the output does not change because of the write.
- R5: A clock edge with `upd` = 1 copies the pending step and phase shift of all four profiles into the working set, including profiles that are not selected.
- R6: When a write and `upd` fall on the same edge, the newly written value is the one committed.
- R7: `psel` is registered. After the edge that captures a new value, `phase_out` uses the new profile's phase shift, and the next accumulation uses its step. The accumulator is not reset, so phase stays continuous.
- R8: `phase_out` equals accumulator bits [31:18] plus the working phase shift of the registered profile, modulo 2^14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write one pending profile field |
| wr_prof | input | 2 | Profile index for the write |
| wr_kind | input | 1 | 0: frequency step, 1: phase shift |
| wr_data | input | 32 | Write value (phase shift uses bits 13:0) |
| upd | input | 1 | Commit all pending fields to the working set |
| psel | input | 2 | Active profile select |
| sweep | input | 1 | 1: use swept step, 0: use profile step |
| sweep_ftw | input | 32 | External swept frequency step |
| phase_out | output | 14 | Output phase |

## Verification
A register write and a commit strobe can land on the same clock edge. In that case the value being written must be committed, not the old pending value. The bench provokes this by writing a new step to the active profile in the same cycle that `upd` is raised. It then judges the phase slope on the following cycles against a model that applies the write before the copy. A profile switch and a commit are also made to coincide, to show that the newly selected profile's fresh values are used at once.

// File: rtl/dds_phase_gen.sv
module dds_phase_gen #(
  parameter int ACC_W = 32,
  parameter int OFS_W = 14,
  parameter int NPROF = 4,
  localparam int SEL_W = $clog2(NPROF)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_prof,
  input  logic             wr_kind,
  input  logic [ACC_W-1:0] wr_data,
  input  logic             upd,
  input  logic [SEL_W-1:0] psel,
  input  logic             sweep,
  input  logic [ACC_W-1:0] sweep_ftw,
  output logic [OFS_W-1:0] phase_out
);

  logic [NPROF-1:0][ACC_W-1:0] pend_ftw, act_ftw, nxt_ftw;
  logic [NPROF-1:0][OFS_W-1:0] pend_ofs, act_ofs, nxt_ofs;
  logic [SEL_W-1:0]            psel_q;
  logic [ACC_W-1:0]            acc, step;

  always_comb begin
    nxt_ftw = pend_ftw;
    nxt_ofs = pend_ofs;
    if (wr_en && !wr_kind) nxt_ftw[wr_prof] = wr_data;
    if (wr_en &&  wr_kind) nxt_ofs[wr_prof] = wr_data[OFS_W-1:0];
  end

  assign step      = sweep ? sweep_ftw : act_ftw[psel_q];
  assign phase_out = acc[ACC_W-1 -: OFS_W] + act_ofs[psel_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_ftw <= '0;
      pend_ofs <= '0;
      act_ftw  <= '0;
      act_ofs  <= '0;
      psel_q   <= '0;
      acc      <= '0;
    end else begin
      pend_ftw <= nxt_ftw;
      pend_ofs <= nxt_ofs;
      if (upd) begin
        act_ftw <= nxt_ftw;
        act_ofs <= nxt_ofs;
      end
      psel_q <= psel;
      acc    <= acc + step;
    end
  end

endmodule

// File: rtl/dds_phase_gen_chk.sv
module dds_phase_gen_chk #(
  parameter int ACC_W = 32,
  parameter int OFS_W = 14,
  parameter int NPROF = 4,
  localparam int SEL_W = $clog2(NPROF)
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        wr_en,
  input logic                        upd,
  input logic [SEL_W-1:0]            psel,
  input logic                        sweep,
  input logic [ACC_W-1:0]            sweep_ftw,
  input logic [OFS_W-1:0]            phase_out,
  input logic [ACC_W-1:0]            acc,
  input logic [SEL_W-1:0]            psel_q,
  input logic [NPROF-1:0][ACC_W-1:0] act_ftw,
  input logic [NPROF-1:0][ACC_W-1:0] pend_ftw
);

  logic seen = 1'b0;
  logic armed = 1'b0;

  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b1;
    armed <= seen && !rst;
  end

  assert_reset_zero_R1: assert property (@(posedge clk)
    seen && $past(rst) |-> phase_out == '0);

  assert_tone_step_R2: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(sweep) |-> acc == $past(acc) + $past(act_ftw[psel_q]));

  assert_sweep_step_R3: assert property (@(posedge clk) disable iff (rst)
    armed && $past(sweep) |-> acc == $past(acc) + $past(sweep_ftw));

  assert_hold_no_commit_R4: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(upd) |-> act_ftw == $past(act_ftw));

  assert_commit_copy_R5: assert property (@(posedge clk) disable iff (rst)
    armed && $past(upd) && !$past(wr_en) |-> act_ftw == $past(pend_ftw));

  assert_select_reg_R7: assert property (@(posedge clk) disable iff (rst)
    armed |-> psel_q == $past(psel));

endmodule

bind dds_phase_gen dds_phase_gen_chk #(.ACC_W(ACC_W), .OFS_W(OFS_W), .NPROF(NPROF)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .upd(upd), .psel(psel), .sweep(sweep),
  .sweep_ftw(sweep_ftw), .phase_out(phase_out), .acc(acc), .psel_q(psel_q),
  .act_ftw(act_ftw), .pend_ftw(pend_ftw)
);

// File: tb/sim_dds_phase_gen.sv
`timescale 1ns/1ps
module sim_dds_phase_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_prof = '0;
  logic        wr_kind = 1'b0;
  logic [31:0] wr_data = '0;
  logic        upd = 1'b0;
  logic [1:0]  psel = '0;
  logic        sweep = 1'b0;
  logic [31:0] sweep_ftw = '0;
  logic [13:0] phase_out;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dds_phase_gen u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_prof(wr_prof), .wr_kind(wr_kind),
    .wr_data(wr_data), .upd(upd), .psel(psel), .sweep(sweep),
    .sweep_ftw(sweep_ftw), .phase_out(phase_out)
  );

  logic [31:0] m_acc;
  logic [1:0]  m_sel;
  logic [31:0] m_pf [4];
  logic [13:0] m_po [4];
  logic [31:0] m_af [4];
  logic [13:0] m_ao [4];

  always @(posedge clk) begin
    if (rst) begin
      m_acc = '0;
      m_sel = '0;
      for (int i = 0; i < 4; i++) begin
        m_pf[i] = '0; m_po[i] = '0; m_af[i] = '0; m_ao[i] = '0;
      end
    end else begin
      m_acc = m_acc + (sweep ? sweep_ftw : m_af[m_sel]);
      m_sel = psel;
      if (wr_en && !wr_kind) m_pf[wr_prof] = wr_data;
      if (wr_en &&  wr_kind) m_po[wr_prof] = wr_data[13:0];
      if (upd) begin
        for (int i = 0; i < 4; i++) begin
          m_af[i] = m_pf[i]; m_ao[i] = m_po[i];
        end
      end
    end
  end

  function automatic logic [13:0] model_phase();
    return m_acc[31:18] + m_ao[m_sel];
  endfunction

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check(string req, logic [13:0] exp);
    total++;
    if (phase_out !== exp) begin
      bad++;
      $display("FAIL %s phase_out=%h expected=%h", req, phase_out, exp);
    end
  endtask

  task automatic run_check(string req, int n);
    for (int i = 0; i < n; i++) begin
      tick();
      check(req, model_phase());
    end
  endtask

  task automatic wr(logic [1:0] p, logic k, logic [31:0] d, logic commit);
    wr_en = 1'b1; wr_prof = p; wr_kind = k; wr_data = d; upd = commit;
    tick();
    wr_en = 1'b0; upd = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tick(); tick();
    check("R1 reset", 14'h0);
    rst = 1'b0;
    run_check("R1 idle after reset", 3);
    check("R1 zero profiles", 14'h0);
  endtask

  task automatic t_tone();
    wr(2'd0, 1'b0, 32'h0100_0000, 1'b0);
    upd = 1'b1; tick(); upd = 1'b0;
    run_check("R2 tone", 5);
    tick();
    check("R2 slope", model_phase());
  endtask

  task automatic t_buffered();
    wr(2'd0, 1'b0, 32'h0800_0000, 1'b0);
    run_check("R4 pending write ignored", 4);
    wr(2'd0, 1'b1, 32'h0000_1234, 1'b0);
    run_check("R4 pending offset ignored", 2);
    upd = 1'b1; tick(); upd = 1'b0;
    check("R5 commit", model_phase());
    run_check("R5 new step", 3);
  endtask

  task automatic t_switch();
    wr(2'd1, 1'b0, 32'h0004_0000, 1'b0);
    wr(2'd1, 1'b1, 32'h0000_3FFF, 1'b1);
    run_check("R5 inactive profile committed", 2);
    psel = 2'd1;
    tick();
    check("R7 offset follows select", model_phase());
    run_check("R7 continuous phase", 4);
    run_check("R8 offset wrap", 2);
    psel = 2'd0;
    run_check("R7 switch back", 3);
  endtask

  task automatic t_same_cycle();
    wr(2'd0, 1'b0, 32'h2000_0000, 1'b1);
    check("R6 write with commit", model_phase());
    run_check("R6 new value used", 3);
    wr(2'd2, 1'b1, 32'h0000_0100, 1'b0);
    wr(2'd2, 1'b0, 32'h0010_0000, 1'b0);
    psel = 2'd2; upd = 1'b1;
    tick();
    upd = 1'b0;
    check("R7 switch with commit", model_phase());
    run_check("R5 fresh profile in use", 3);
  endtask

  task automatic t_sweep();
    sweep = 1'b1; sweep_ftw = 32'hFFF0_0000;
    run_check("R3 sweep down", 4);
    sweep_ftw = 32'h0123_4567;
    run_check("R3 sweep up", 4);
    sweep = 1'b0;
    run_check("R2 back to tone", 3);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_tone();
    t_buffered();
    t_switch();
    t_same_cycle();
    t_sweep();
    t_reset();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule